// File: doc/BRIEF.md
# HDLC Receive Deframer with Frame Check

This block turns a serial bit stream, qualified by a per-cycle bit-valid strobe, into received message bytes. In its framed mode it hunts for the 01111110 delimiter, deletes the zero a transmitter inserts after five ones, and assembles the surviving bits into bytes, with the first bit received in bit 0. It can check a 16-bit frame check sequence over each frame. Every completed message ends with a one-cycle end-of-message event that carries an outcome code.

The trailing two check bytes are held back and never written. Because of this, every byte the block writes is followed by an outcome that says whether the downstream store should keep or discard the bytes written since the last event. Two raw modes skip framing completely. In these modes every valid bit is packed, either as 8-bit words or as 6-bit words in the low bits. A partial outcome is raised after each fixed-size block of raw words.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A synchronous reset clears wr_en, eom_vld and wr_data to zero. In framed mode (mode 00) the block then writes nothing and raises no event until it has seen an opening flag.
- R2: The flag is 01111110. Consecutive flags and frames shorter than 16 bits between flags raise no event and write no byte.
- R3: Framed-mode bytes are packed LSB first (first bit in bit 0). All bytes except the last two before the closing flag are written in order. A valid frame gives eom_vld with eom_code 00 (good), and each write comes before its frame's event.
- R4: A zero that follows five consecutive ones inside a frame is removed and is not packed.
- R5: With fcs_en=1, the block runs a CRC-16 over all destuffed frame bits, including the two trailer bytes. The CRC uses the reflected polynomial 0x8408 and a preset of 0xFFFF. A residue other than 0xF0B8 gives eom_code 01.
- R6: With fcs_en=0 the check is skipped. A frame with a corrupted trailer still reports 00, and its two trailer bytes are still withheld.
- R7: A closing flag after at least 16 data bits gives eom_code 01 when the bit count is not a multiple of 8.
- R8: Seven consecutive ones after at least one packed data bit give eom_code 10 (abort). The block then returns to hunt, and data before the next flag is ignored.
- R9: In mode 01 every 8 valid bits give one write, LSB first. Every RAW_BLOCK-th write (4 by default) carries eom_code 11 (partial) in the same cycle.
- R10: In mode 10 every 6 valid bits give one write, with the bits in wr_data[5:0] LSB first and wr_data[7:6] zero. The same partial rule as R9 applies.
- R11: wr_en and eom_vld are single-cycle pulses, registered one cycle after the bit that causes them. Cycles with bit_vld low have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 framed, 01 raw 8-bit, 10 raw 6-bit |
| fcs_en | input | 1 | Enable the frame check in framed mode |
| bit_vld | input | 1 | bit_in is valid this cycle |
| bit_in | input | 1 | Serial line bit |
| wr_en | output | 1 | Write strobe for wr_data |
| wr_data | output | DATA_W | Received byte or raw word |
| eom_vld | output | 1 | End-of-message event |
| eom_code | output | 2 | 00 good, 01 check/length error, 10 abort, 11 partial |

## Verification
The bench sends frames whose data bytes hold runs of ones. A design that failed to remove stuffed zeros would write shifted, wrong bytes. It sends back-to-back flags and a one-byte frame, which a careless close decision would report as errors. It corrupts the trailer with the check on and with the check off, which shows whether fcs_en really gates the check while the trailer is still withheld. It also ends a frame on a non-octet boundary and aborts a frame midway. A receiver that left hunt early after an abort would emit events from the trailing garbage, and one that packed in the wrong bit order or alignment would give wrong raw 6-bit words.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   typedef enum logic [1:0] {
      EOM_GOOD  = 2'b00,
      EOM_ERR   = 2'b01,
      EOM_ABORT = 2'b10,
      EOM_PART  = 2'b11
   } eom_code_t;

   typedef enum logic {
      ST_HUNT,
      ST_FRAME
   } rx_state_t;
endpackage

// File: rtl/hdlc_rx_linedec.sv
// Line decoder: run-of-ones tracking, flag/abort detection, zero removal,
// and a delay line that keeps flag bits away from the byte packer.
module hdlc_rx_linedec #(
   parameter int RUN_FLAG = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_vld,
   input  logic bit_in,
   output logic dat_vld,
   output logic dat_bit,
   output logic flag_hit,
   output logic run_abort
);
   localparam int DLY = RUN_FLAG + 1;
   localparam int OW  = $clog2(RUN_FLAG + 2);
   localparam int FW  = $clog2(DLY + 1);
   localparam logic [OW-1:0] ONES_FLAG  = OW'(RUN_FLAG);
   localparam logic [OW-1:0] ONES_STUFF = OW'(RUN_FLAG - 1);
   localparam logic [OW-1:0] ONES_SAT   = OW'(RUN_FLAG + 1);
   localparam logic [FW-1:0] FILL_FULL  = FW'(DLY);

   if (RUN_FLAG < 2) begin : g_bad_run
      $error("RUN_FLAG must be at least 2");
   end

   logic [OW-1:0]  ones;
   logic [DLY-1:0] dl;
   logic [FW-1:0]  fill;
   logic           stuff;
   logic           push;

   always_comb begin
      flag_hit  = bit_vld && !bit_in && (ones == ONES_FLAG);
      run_abort = bit_vld &&  bit_in && (ones == ONES_FLAG);
      stuff     = bit_vld && !bit_in && (ones == ONES_STUFF);
      push      = bit_vld && !flag_hit && !run_abort && !stuff;
      dat_vld   = push && (fill == FILL_FULL);
      dat_bit   = dl[DLY-1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ones <= '0;
         dl   <= '0;
         fill <= '0;
      end else if (bit_vld) begin
         if (!bit_in)
            ones <= '0;
         else if (ones != ONES_SAT)
            ones <= ones + 1'b1;
         if (flag_hit || run_abort)
            fill <= '0;
         else if (push) begin
            dl <= {dl[DLY-2:0], bit_in};
            if (fill != FILL_FULL)
               fill <= fill + 1'b1;
         end
      end
   end

   // R4: an inserted zero never enters the delay line
   a_r4_stuff_dropped: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !bit_in && ones == ONES_STUFF) |=> (fill == $past(fill)));
endmodule

// File: rtl/hdlc_rx_fcs.sv
// Bit-serial reflected CRC with residue compare.
module hdlc_rx_fcs #(
   parameter int          W       = 16,
   parameter logic [W-1:0] POLY    = 16'h8408,
   parameter logic [W-1:0] PRESET  = 16'hFFFF,
   parameter logic [W-1:0] RESIDUE = 16'hF0B8
) (
   input  logic clk,
   input  logic rst,
   input  logic init,
   input  logic upd,
   input  logic din,
   output logic match
);
   logic [W-1:0] crc;

   always_ff @(posedge clk) begin
      if (rst || init)
         crc <= PRESET;
      else if (upd)
         crc <= (crc >> 1) ^ ({W{crc[0] ^ din}} & POLY);
   end

   assign match = (crc == RESIDUE);
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int RAW_NARROW = 6,
   parameter int RAW_BLOCK  = 4,
   parameter int FCS_W      = 16,
   parameter bit BUILD_FCS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode,
   input  logic              fcs_en,
   input  logic              bit_vld,
   input  logic              bit_in,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              eom_vld,
   output logic [1:0]        eom_code
);
   localparam int TRAIL = FCS_W / 8;
   localparam int BCW   = $clog2(DATA_W);
   localparam int NBW   = $clog2(TRAIL + 1);
   localparam int RBW   = $clog2(RAW_BLOCK + 1);
   localparam int SHIFT = DATA_W - RAW_NARROW;
   localparam logic [BCW-1:0] LAST_W  = BCW'(DATA_W - 1);
   localparam logic [BCW-1:0] LAST_N  = BCW'(RAW_NARROW - 1);
   localparam logic [NBW-1:0] TRAIL_C = NBW'(TRAIL);
   localparam logic [RBW-1:0] RB_LAST = RBW'(RAW_BLOCK - 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("DATA_W must be 8");
   end
   if (RAW_NARROW < 1 || RAW_NARROW > DATA_W) begin : g_bad_narrow
      $error("RAW_NARROW out of range");
   end
   if (RAW_BLOCK < 1) begin : g_bad_block
      $error("RAW_BLOCK must be positive");
   end
   if (FCS_W % 8 != 0 || FCS_W < 8) begin : g_bad_fcs
      $error("FCS_W must be a multiple of 8");
   end

   logic dat_vld, dat_bit, flag_hit, run_abort, crc_match;

   hdlc_rx_linedec #(.RUN_FLAG(6)) i_linedec (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
      .dat_vld(dat_vld), .dat_bit(dat_bit),
      .flag_hit(flag_hit), .run_abort(run_abort)
   );

   rx_state_t          st;
   logic [DATA_W-1:0]  sr;
   logic [BCW-1:0]     bitcnt;
   logic [NBW-1:0]     nbytes;
   logic [NBW-1:0]     hcnt;
   logic [DATA_W-1:0]  hold [TRAIL];
   logic [RBW-1:0]     rawcnt;
   logic               raw, narrow, pbit, crc_ok;
   logic [BCW-1:0]     last_idx;
   logic [DATA_W-1:0]  nxt;

   always_comb begin
      raw      = (mode != 2'b00);
      narrow   = mode[1];
      pbit     = raw ? bit_in : dat_bit;
      nxt      = {pbit, sr[DATA_W-1:1]};
      last_idx = (raw && narrow) ? LAST_N : LAST_W;
   end

   if (BUILD_FCS) begin : g_fcs
      hdlc_rx_fcs #(.W(16)) i_fcs (
         .clk(clk), .rst(rst),
         .init(flag_hit),
         .upd(!raw && dat_vld && st == ST_FRAME),
         .din(dat_bit),
         .match(crc_match)
      );
   end else begin : g_no_fcs
      assign crc_match = 1'b1;
   end

   assign crc_ok = crc_match || !fcs_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_HUNT;
         sr       <= '0;
         bitcnt   <= '0;
         nbytes   <= '0;
         hcnt     <= '0;
         rawcnt   <= '0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
         eom_vld  <= 1'b0;
         eom_code <= EOM_GOOD;
         for (int i = 0; i < TRAIL; i++) hold[i] <= '0;
      end else begin
         wr_en   <= 1'b0;
         eom_vld <= 1'b0;
         if (raw) begin
            if (bit_vld) begin
               sr <= nxt;
               if (bitcnt == last_idx) begin
                  bitcnt  <= '0;
                  wr_en   <= 1'b1;
                  wr_data <= narrow ? (nxt >> SHIFT) : nxt;
                  if (rawcnt == RB_LAST) begin
                     rawcnt   <= '0;
                     eom_vld  <= 1'b1;
                     eom_code <= EOM_PART;
                  end else begin
                     rawcnt <= rawcnt + 1'b1;
                  end
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
         end else if (flag_hit) begin
            if (st == ST_FRAME && nbytes == TRAIL_C) begin
               eom_vld <= 1'b1;
               if (bitcnt != '0 || !crc_ok)
                  eom_code <= EOM_ERR;
               else
                  eom_code <= EOM_GOOD;
            end
            st     <= ST_FRAME;
            bitcnt <= '0;
            nbytes <= '0;
            hcnt   <= '0;
         end else if (st == ST_FRAME) begin
            if (run_abort) begin
               if (nbytes != '0 || bitcnt != '0) begin
                  eom_vld  <= 1'b1;
                  eom_code <= EOM_ABORT;
               end
               st <= ST_HUNT;
            end else if (dat_vld) begin
               sr <= nxt;
               if (bitcnt == LAST_W) begin
                  bitcnt <= '0;
                  if (nbytes != TRAIL_C) nbytes <= nbytes + 1'b1;
                  if (hcnt == TRAIL_C) begin
                     wr_en   <= 1'b1;
                     wr_data <= hold[0];
                     for (int i = 0; i < TRAIL - 1; i++) hold[i] <= hold[i+1];
                     hold[TRAIL-1] <= nxt;
                  end else begin
                     for (int i = 0; i < TRAIL; i++)
                        if (NBW'(i) == hcnt) hold[i] <= nxt;
                     hcnt <= hcnt + 1'b1;
                  end
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
         end
      end
   end

   // R11: events and writes last one cycle
   a_r11_eom_pulse: assert property (@(posedge clk) disable iff (rst)
      eom_vld |=> !eom_vld);
   a_r11_wr_pulse: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);
   // R9: raw modes only ever report partial
   a_r9_raw_partial: assert property (@(posedge clk) disable iff (rst)
      (eom_vld && raw) |-> (eom_code == EOM_PART));
   // R3: framed mode never reports partial
   a_r3_framed_no_partial: assert property (@(posedge clk) disable iff (rst)
      (eom_vld && !raw) |-> (eom_code != EOM_PART));
   // R8: while hunting, framed mode produces nothing
   a_r8_hunt_silent: assert property (@(posedge clk) disable iff (rst)
      (!raw && st == ST_HUNT) |=> (!wr_en && !eom_vld));
   // R10: narrow raw words leave the upper bits clear
   a_r10_narrow_upper: assert property (@(posedge clk) disable iff (rst)
      (wr_en && $past(raw && narrow)) |-> (wr_data[DATA_W-1:RAW_NARROW] == '0));
endmodule

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       fcs_en = 1'b1;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       wr_en, eom_vld;
   logic [7:0] wr_data;
   logic [1:0] eom_code;

   always #4 clk = ~clk;

   hdlc_rx_deframer i_hdlc_rx_deframer (
      .clk(clk), .rst(rst), .mode(mode), .fcs_en(fcs_en),
      .bit_vld(bit_vld), .bit_in(bit_in),
      .wr_en(wr_en), .wr_data(wr_data),
      .eom_vld(eom_vld), .eom_code(eom_code)
   );

   int nchk = 0, nerr = 0;
   int tx_ones = 0;
   logic [7:0] got_d[$];
   logic [1:0] got_e[$];
   int         got_at[$];
   logic [7:0] tx_q[$];

   always @(negedge clk) begin
      if (!rst) begin
         if (wr_en) got_d.push_back(wr_data);
         if (eom_vld) begin
            got_e.push_back(eom_code);
            got_at.push_back(got_d.size());
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clr();
      got_d.delete(); got_e.delete(); got_at.delete();
   endtask

   task automatic do_reset(input logic [1:0] m, input logic f);
      @(negedge clk);
      rst = 1'b1; mode = m; fcs_en = f; bit_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      tx_ones = 0;
      clr();
   endtask

   task automatic send_bit(input logic b, input int gap);
      bit_vld = 1'b1; bit_in = b;
      @(negedge clk);
      bit_vld = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic idle(input int n);
      bit_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_dbit(input logic b, input int gap);
      send_bit(b, gap);
      if (b) begin
         tx_ones++;
         if (tx_ones == 5) begin
            send_bit(1'b0, gap);
            tx_ones = 0;
         end
      end else tx_ones = 0;
   endtask

   task automatic send_dbyte(input logic [7:0] v, input int gap);
      for (int i = 0; i < 8; i++) send_dbit(v[i], gap);
   endtask

   task automatic send_raw_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i], 0);
   endtask

   task automatic send_flag(input int gap);
      send_bit(1'b0, gap);
      for (int i = 0; i < 6; i++) send_bit(1'b1, gap);
      send_bit(1'b0, gap);
      tx_ones = 0;
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      crc_step = (c >> 1) ^ (((c[0] ^ b) != 1'b0) ? 16'h8408 : 16'h0000);
   endfunction

   task automatic send_frame(input logic [15:0] corrupt, input int gap);
      logic [15:0] c;
      c = 16'hFFFF;
      send_flag(gap);
      foreach (tx_q[k]) begin
         for (int i = 0; i < 8; i++) c = crc_step(c, tx_q[k][i]);
         send_dbyte(tx_q[k], gap);
      end
      c = ~c ^ corrupt;
      send_dbyte(c[7:0], gap);
      send_dbyte(c[15:8], gap);
      send_flag(gap);
      idle(4);
   endtask

   task automatic check_data(input string req);
      chk(got_d.size() == tx_q.size(), req, "write count", got_d.size(), tx_q.size());
      foreach (tx_q[k])
         if (k < got_d.size())
            chk(got_d[k] == tx_q[k], req, "data byte", got_d[k], tx_q[k]);
   endtask

   task automatic check_one_eom(input string req, input logic [1:0] code);
      chk(got_e.size() == 1, req, "event count", got_e.size(), 1);
      if (got_e.size() > 0)
         chk(got_e[0] == code, req, "event code", got_e[0], code);
   endtask

   task automatic t_reset_hunt();
      do_reset(2'b00, 1'b1);
      chk(wr_en == 1'b0 && eom_vld == 1'b0, "R1", "outputs after reset",
          {wr_en, eom_vld}, 0);
      chk(wr_data == 8'h00, "R1", "wr_data after reset", wr_data, 0);
      send_raw_byte(8'h00); send_raw_byte(8'hAA);
      send_raw_byte(8'h55); send_raw_byte(8'h3C);
      idle(4);
      chk(got_d.size() == 0 && got_e.size() == 0, "R1", "activity before flag",
          got_d.size() + got_e.size(), 0);
   endtask

   task automatic t_good_stuffed();
      do_reset(2'b00, 1'b1);
      tx_q = '{8'h12, 8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'hA5};
      send_frame(16'h0000, 0);
      check_data("R4");
      check_one_eom("R3", 2'b00);
      if (got_at.size() > 0)
         chk(got_at[0] == tx_q.size(), "R3", "writes before event", got_at[0], tx_q.size());
   endtask

   task automatic t_short_frames();
      do_reset(2'b00, 1'b1);
      send_flag(0); send_flag(0); send_flag(0);
      send_dbyte(8'h5A, 0);
      send_flag(0); send_flag(0);
      idle(4);
      chk(got_d.size() == 0 && got_e.size() == 0, "R2", "short frame activity",
          got_d.size() + got_e.size(), 0);
   endtask

   task automatic t_fcs_bad();
      do_reset(2'b00, 1'b1);
      tx_q = '{8'h01, 8'h02, 8'h03};
      send_frame(16'h0010, 0);
      check_one_eom("R5", 2'b01);
   endtask

   task automatic t_fcs_off();
      do_reset(2'b00, 1'b0);
      tx_q = '{8'hC3, 8'h99, 8'h00, 8'h7F};
      send_frame(16'h8001, 0);
      check_data("R6");
      check_one_eom("R6", 2'b00);
   endtask

   task automatic t_nonint();
      do_reset(2'b00, 1'b1);
      send_flag(0);
      send_dbyte(8'h10, 0); send_dbyte(8'h20, 0); send_dbyte(8'h30, 0);
      send_dbit(1'b1, 0); send_dbit(1'b0, 0); send_dbit(1'b1, 0);
      send_flag(0);
      idle(4);
      check_one_eom("R7", 2'b01);
   endtask

   task automatic t_abort();
      do_reset(2'b00, 1'b1);
      send_flag(0);
      send_dbyte(8'h11, 0); send_dbyte(8'h22, 0);
      for (int i = 0; i < 8; i++) send_bit(1'b1, 0);
      idle(4);
      check_one_eom("R8", 2'b10);
      chk(got_d.size() == 0, "R8", "writes of aborted frame", got_d.size(), 0);
      clr();
      send_raw_byte(8'h00); send_raw_byte(8'h6C); send_raw_byte(8'h00);
      idle(4);
      chk(got_d.size() == 0 && got_e.size() == 0, "R8", "activity after abort",
          got_d.size() + got_e.size(), 0);
      tx_q = '{8'hDE, 8'hAD};
      send_frame(16'h0000, 0);
      check_data("R8");
      check_one_eom("R8", 2'b00);
   endtask

   task automatic t_gaps();
      do_reset(2'b00, 1'b1);
      tx_q = '{8'hFE, 8'h0F, 8'h81};
      send_frame(16'h0000, 2);
      check_data("R11");
      check_one_eom("R11", 2'b00);
   endtask

   task automatic t_raw8();
      logic [7:0] w[8];
      w = '{8'h3C, 8'h81, 8'hF0, 8'h0F, 8'hA5, 8'h5A, 8'h01, 8'h80};
      do_reset(2'b01, 1'b1);
      foreach (w[k]) send_raw_byte(w[k]);
      idle(4);
      chk(got_d.size() == 8, "R9", "raw8 write count", got_d.size(), 8);
      foreach (w[k])
         if (k < got_d.size())
            chk(got_d[k] == w[k], "R9", "raw8 word", got_d[k], w[k]);
      chk(got_e.size() == 2, "R9", "raw8 event count", got_e.size(), 2);
      if (got_e.size() == 2) begin
         chk(got_e[0] == 2'b11 && got_e[1] == 2'b11, "R9", "raw8 codes",
             {got_e[0], got_e[1]}, 4'hF);
         chk(got_at[0] == 4 && got_at[1] == 8, "R9", "raw8 event position",
             got_at[0] * 16 + got_at[1], 16'h48);
      end
   endtask

   task automatic t_raw6();
      logic [5:0] w[4];
      w = '{6'h2A, 6'h15, 6'h3F, 6'h01};
      do_reset(2'b10, 1'b1);
      foreach (w[k])
         for (int i = 0; i < 6; i++) send_bit(w[k][i], 0);
      idle(4);
      chk(got_d.size() == 4, "R10", "raw6 write count", got_d.size(), 4);
      foreach (w[k])
         if (k < got_d.size())
            chk(got_d[k] == {2'b00, w[k]}, "R10", "raw6 word", got_d[k], {2'b00, w[k]});
      chk(got_e.size() == 1, "R10", "raw6 event count", got_e.size(), 1);
      if (got_e.size() == 1)
         chk(got_e[0] == 2'b11 && got_at[0] == 4, "R10", "raw6 event",
             got_e[0] * 16 + got_at[0], 8'h34);
   endtask

   bit done = 1'b0;

   initial begin
      t_reset_hunt();
      t_good_stuffed();
      t_short_frames();
      t_fcs_bad();
      t_fcs_off();
      t_nonint();
      t_abort();
      t_gaps();
      t_raw8();
      t_raw6();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule